// File: doc/BRIEF.md
# Two-Channel ADC Sample Serializer with Loopback Receiver

This block turns a pair of 20-bit converter samples, one for channel A and one for channel B, into a serial stream. A new pair is taken once per sample period. The block runs on a bit-slot clock: each cycle of `clk` is one bit slot, and in that slot every active lane carries one bit. Three run-time settings shape the stream. The frame width is 20 or 24 bits. The output uses one lane or two lanes. The data clock runs in SDR or DDR mode. The sample period lasts 2 × width ÷ lanes bit slots.

The data clock is reported through `dclk_rise`, which marks each slot in which a data-clock rising edge would be launched. In SDR this is every slot. In DDR it is every second slot, because a DDR lane carries two bits per data-clock period. `frame_start` marks the first slot of each sample period, so the data clock stays phase-locked to the sample boundary. A receive-side deserializer inside the block reads the lanes back. It realigns on `frame_start`, rebuilds both channel words and presents them once per period, which lets the link be checked end to end.

Top module: `adc_ser_link`

## Requirements
- R1: While `rst` is high and in the cycle that follows reset, `lane0`, `lane1`, `frame_start`, `dclk_rise` and `rx_valid` are all 0.
- R2: Each channel frame carries its 20-bit sample MSB first. In 24-bit mode (`cfg_wide`=1), four 0 bits follow the sample LSB.
- R3: With one lane (`cfg_two_lane`=0), `lane0` carries the whole channel A frame and then the whole channel B frame, and `lane1` stays 0.
- R4: With two lanes (`cfg_two_lane`=1), channel A goes on `lane0` and channel B on `lane1`, both starting in the same slot.
- R5: The number of `dclk_rise` slots in one sample period equals 2 × width ÷ (lanes × rate), where the rate is 1 for SDR and 2 for DDR. This gives 48/24/24/12 for 24-bit frames and 40/20/20/10 for 20-bit frames.
- R6: In SDR (`cfg_ddr`=0), `dclk_rise` is high in every slot. In DDR it is high only in even slots of the period, counting from slot 0.
- R7: `frame_start` is high only in slot 0 of each sample period, which is the slot that carries the first bit.
- R8: Samples and all three settings are captured only at the clock edge that starts a period. Changes at any other time do not alter the period in progress.
- R9: `rx_valid` pulses for one cycle, in slot 0 of the following period, and `rx_a`/`rx_b` then hold the samples sent in the period that has just ended.
- R10: The first sample period begins at the first clock edge after `rst` falls, so `frame_start` is high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_a | input | 20 | Channel A sample |
| smp_b | input | 20 | Channel B sample |
| cfg_wide | input | 1 | 1 = 24-bit frames, 0 = 20-bit frames |
| cfg_two_lane | input | 1 | 1 = two lanes, 0 = one lane |
| cfg_ddr | input | 1 | 1 = DDR data clock, 0 = SDR |
| lane0 | output | 1 | Serial lane 0 |
| lane1 | output | 1 | Serial lane 1 |
| dclk_rise | output | 1 | Data-clock rising edge launched in this slot |
| frame_start | output | 1 | First slot of a sample period |
| rx_valid | output | 1 | Receiver words valid |
| rx_a | output | 20 | Rebuilt channel A sample |
| rx_b | output | 20 | Rebuilt channel B sample |

## Verification
Several events fall in the same cycle at a period boundary. The receiver finishes the old period and raises `rx_valid`, while the transmitter latches a new format and new samples and raises `frame_start`. To provoke this, the bench changes the settings and the sample values at arbitrary cycles across all eight formats, so a format change often lands just before a boundary. The behavioural model then judges each boundary. It expects the old samples, decoded in the old format, to come out in the same slot as the first bit of the new format. It also expects the `dclk_rise` count of the finished period to match the old settings.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    localparam int SAMPLE_W = 20;
    localparam int FRAME_HI = 24;
    localparam int PAD_W    = FRAME_HI - SAMPLE_W;
    localparam int LONG_W   = 2 * FRAME_HI;
    localparam int CNT_W    = $clog2(LONG_W);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic wide;
        logic two_lane;
        logic ddr;
    } link_cfg_t;

    // bit slots in one sample period for a given format
    function automatic logic [CNT_W-1:0] slots_per_period(input link_cfg_t c);
        int w;
        w = c.wide ? FRAME_HI : SAMPLE_W;
        return CNT_W'(c.two_lane ? w : 2 * w);
    endfunction

    // sample left-aligned in the widest frame, zero tail
    function automatic logic [FRAME_HI-1:0] frame_bits(input sample_t s);
        return {s, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/adc_ser_slot_timer.sv
module adc_ser_slot_timer
    import adc_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  link_cfg_t        cfg_req,
    output logic             load,
    output link_cfg_t        cfg_act,
    output logic [CNT_W-1:0] slot,
    output logic             running
);

    logic             first_q;
    logic [CNT_W-1:0] last_slot;

    assign last_slot = slots_per_period(cfg_act) - CNT_W'(1);
    assign load      = first_q || (slot == last_slot);
    assign running   = !first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b1;
            slot    <= '0;
            cfg_act <= '0;
        end else if (load) begin
            first_q <= 1'b0;
            slot    <= '0;
            cfg_act <= cfg_req;
        end else begin
            slot    <= slot + CNT_W'(1);
        end
    end

endmodule

// File: rtl/adc_ser_tx.sv
module adc_ser_tx
    import adc_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  link_cfg_t        cfg_req,
    input  link_cfg_t        cfg_act,
    input  logic [CNT_W-1:0] slot,
    input  logic             running,
    input  sample_t          smp_a,
    input  sample_t          smp_b,
    output logic             lane0,
    output logic             lane1,
    output logic             dclk_rise,
    output logic             frame_start
);

    logic [LONG_W-1:0]   sh0_q, img0;
    logic [FRAME_HI-1:0] sh1_q, img1;
    logic [FRAME_HI-1:0] fa, fb;
    logic                fs_q;

    assign fa = frame_bits(smp_a);
    assign fb = frame_bits(smp_b);

    always_comb begin
        if (cfg_req.two_lane) begin
            img0 = {fa, {FRAME_HI{1'b0}}};
            img1 = fb;
        end else if (cfg_req.wide) begin
            img0 = {fa, fb};
            img1 = '0;
        end else begin
            img0 = {smp_a, smp_b, {(LONG_W - 2*SAMPLE_W){1'b0}}};
            img1 = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh0_q <= '0;
            sh1_q <= '0;
            fs_q  <= 1'b0;
        end else if (load) begin
            sh0_q <= img0;
            sh1_q <= img1;
            fs_q  <= 1'b1;
        end else begin
            sh0_q <= {sh0_q[LONG_W-2:0], 1'b0};
            sh1_q <= {sh1_q[FRAME_HI-2:0], 1'b0};
            fs_q  <= 1'b0;
        end
    end

    assign lane0       = sh0_q[LONG_W-1];
    assign lane1       = sh1_q[FRAME_HI-1];
    assign frame_start = fs_q;
    assign dclk_rise   = running && (!cfg_act.ddr || !slot[0]);

endmodule

// File: rtl/adc_ser_rx.sv
module adc_ser_rx
    import adc_ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lane0,
    input  logic      lane1,
    input  logic      frame_start,
    input  link_cfg_t cfg,
    output logic      valid,
    output sample_t   word_a,
    output sample_t   word_b
);

    logic [LONG_W-1:0]   sr0_q, nx0;
    logic [FRAME_HI-1:0] sr1_q, nx1;
    logic [CNT_W-1:0]    idx_q, cur_idx;
    logic                locked_q, done;
    sample_t             dec_a, dec_b;

    assign nx0 = {sr0_q[LONG_W-2:0], lane0};
    assign nx1 = {sr1_q[FRAME_HI-2:0], lane1};

    always_comb begin
        if (frame_start)
            cur_idx = '0;
        else if (idx_q != '1)
            cur_idx = idx_q + CNT_W'(1);
        else
            cur_idx = idx_q;
    end

    assign done = (frame_start || locked_q) &&
                  (cur_idx == slots_per_period(cfg) - CNT_W'(1));

    always_comb begin
        if (cfg.two_lane) begin
            dec_a = cfg.wide ? nx0[FRAME_HI-1 -: SAMPLE_W] : nx0[SAMPLE_W-1:0];
            dec_b = cfg.wide ? nx1[FRAME_HI-1 -: SAMPLE_W] : nx1[SAMPLE_W-1:0];
        end else if (cfg.wide) begin
            dec_a = nx0[LONG_W-1 -: SAMPLE_W];
            dec_b = nx0[FRAME_HI-1 -: SAMPLE_W];
        end else begin
            dec_a = nx0[2*SAMPLE_W-1 -: SAMPLE_W];
            dec_b = nx0[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr0_q    <= '0;
            sr1_q    <= '0;
            idx_q    <= '0;
            locked_q <= 1'b0;
            valid    <= 1'b0;
            word_a   <= '0;
            word_b   <= '0;
        end else begin
            sr0_q    <= nx0;
            sr1_q    <= nx1;
            idx_q    <= cur_idx;
            locked_q <= locked_q || frame_start;
            valid    <= done;
            if (done) begin
                word_a <= dec_a;
                word_b <= dec_b;
            end
        end
    end

endmodule

// File: rtl/adc_ser_link.sv
module adc_ser_link
    import adc_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [19:0] smp_a,
    input  logic [19:0] smp_b,
    input  logic        cfg_wide,
    input  logic        cfg_two_lane,
    input  logic        cfg_ddr,
    output logic        lane0,
    output logic        lane1,
    output logic        dclk_rise,
    output logic        frame_start,
    output logic        rx_valid,
    output logic [19:0] rx_a,
    output logic [19:0] rx_b
);

    link_cfg_t        cfg_req, cfg_act;
    logic             load, running;
    logic [CNT_W-1:0] slot;

    assign cfg_req = link_cfg_t'({cfg_wide, cfg_two_lane, cfg_ddr});

    adc_ser_slot_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .cfg_req (cfg_req),
        .load    (load),
        .cfg_act (cfg_act),
        .slot    (slot),
        .running (running)
    );

    adc_ser_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .cfg_req     (cfg_req),
        .cfg_act     (cfg_act),
        .slot        (slot),
        .running     (running),
        .smp_a       (smp_a),
        .smp_b       (smp_b),
        .lane0       (lane0),
        .lane1       (lane1),
        .dclk_rise   (dclk_rise),
        .frame_start (frame_start)
    );

    adc_ser_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .lane0       (lane0),
        .lane1       (lane1),
        .frame_start (frame_start),
        .cfg         (cfg_act),
        .valid       (rx_valid),
        .word_a      (rx_a),
        .word_b      (rx_b)
    );

endmodule

// File: rtl/adc_ser_link_chk.sv
module adc_ser_link_chk
    import adc_ser_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      lane1,
    input logic      frame_start,
    input logic      dclk_rise,
    input logic      rx_valid,
    input link_cfg_t cfg_act
);

    logic [7:0] len_q;
    logic       seen_q;
    link_cfg_t  cfg_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            seen_q <= 1'b0;
            cfg_d  <= '0;
        end else begin
            cfg_d <= cfg_act;
            if (frame_start) begin
                len_q  <= 8'd1;
                seen_q <= 1'b1;
            end else if (len_q != 8'hFF) begin
                len_q  <= len_q + 8'd1;
            end
        end
    end

    // R3: single-lane mode leaves lane 1 idle
    assert_lane1_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_act.two_lane |-> !lane1);

    // R5: period length matches the format of the period just ended
    assert_period_len_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_start && seen_q) |-> (len_q == 8'(slots_per_period(cfg_d))));

    // R6: DDR launches a rising edge at most every other slot
    assert_ddr_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.ddr && dclk_rise) |=> !dclk_rise);

    // R7: period start always carries a rising edge and is never back to back
    assert_start_edge_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> dclk_rise);
    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R8: active format only moves at a period start
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(cfg_act));

    // R9: receiver words appear in slot 0 of the next period
    assert_rx_align_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> frame_start);

endmodule

bind adc_ser_link adc_ser_link_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .lane1       (lane1),
    .frame_start (frame_start),
    .dclk_rise   (dclk_rise),
    .rx_valid    (rx_valid),
    .cfg_act     (cfg_act)
);

// File: tb/tb_adc_ser_link.sv
module tb_adc_ser_link;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] smp_a, smp_b;
    logic        cfg_wide, cfg_two_lane, cfg_ddr;
    logic        lane0, lane1, dclk_rise, frame_start, rx_valid;
    logic [19:0] rx_a, rx_b;

    always #2 clk = ~clk;

    adc_ser_link dut (
        .clk(clk), .rst(rst), .smp_a(smp_a), .smp_b(smp_b),
        .cfg_wide(cfg_wide), .cfg_two_lane(cfg_two_lane), .cfg_ddr(cfg_ddr),
        .lane0(lane0), .lane1(lane1), .dclk_rise(dclk_rise),
        .frame_start(frame_start), .rx_valid(rx_valid), .rx_a(rx_a), .rx_b(rx_b)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    bit          m_first = 1;
    bit          m_fresh = 0;
    int          m_pos   = 0;
    int          m_len   = 40;
    bit          m_wide, m_two, m_ddr;
    bit          bits0[48];
    bit          bits1[48];
    logic [19:0] m_a = '0, m_b = '0;
    bit          e_rxv = 0;
    logic [19:0] e_ra, e_rb;
    bit          rise_chk = 0;
    int          rise_exp = 0;
    int          rise_obs = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit frame_bit(input logic [19:0] s, input int i);
        return (i < 20) ? s[19-i] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_first  = 1;
            m_fresh  = 0;
            m_pos    = 0;
            e_rxv    = 0;
            rise_chk = 0;
        end else if (m_first || m_pos == m_len - 1) begin
            e_rxv   = !m_first;
            e_ra    = m_a;
            e_rb    = m_b;
            if (!m_first) begin
                int wp;
                wp       = m_wide ? 24 : 20;
                rise_exp = 2 * wp / ((m_two ? 2 : 1) * (m_ddr ? 2 : 1));
                rise_chk = 1;
            end
            m_fresh = m_first;
            m_a     = smp_a;
            m_b     = smp_b;
            m_wide  = cfg_wide;
            m_two   = cfg_two_lane;
            m_ddr   = cfg_ddr;
            begin
                int w;
                w     = m_wide ? 24 : 20;
                m_len = m_two ? w : 2 * w;
                for (int i = 0; i < 48; i++) begin
                    bits0[i] = 0;
                    bits1[i] = 0;
                end
                for (int i = 0; i < w; i++) begin
                    bits0[i] = frame_bit(m_a, i);
                    if (m_two) bits1[i] = frame_bit(m_b, i);
                    else       bits0[w+i] = frame_bit(m_b, i);
                end
            end
            m_pos   = 0;
            m_first = 0;
        end else begin
            m_pos++;
            e_rxv   = 0;
            m_fresh = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (m_first) begin
                check("R1 lane0", lane0, 0);
                check("R1 lane1", lane1, 0);
                check("R1 frame_start", frame_start, 0);
                check("R1 dclk_rise", dclk_rise, 0);
                check("R1 rx_valid", rx_valid, 0);
                rise_obs = 0;
            end else begin
                check(m_two ? "R4 lane0" : "R3 lane0", lane0, bits0[m_pos]);
                check(m_two ? "R4/R2 lane1" : "R3 lane1", lane1, bits1[m_pos]);
                check("R2/R8 content", {lane0, lane1}, {bits0[m_pos], bits1[m_pos]});
                check("R7 frame_start", frame_start, m_pos == 0);
                check("R6 dclk_rise", dclk_rise, (!m_ddr || (m_pos % 2 == 0)));
                check("R9 rx_valid", rx_valid, e_rxv);
                if (e_rxv) begin
                    check("R9 rx_a", rx_a, e_ra);
                    check("R9 rx_b", rx_b, e_rb);
                end
                if (m_fresh) check("R10 first period", frame_start, 1);
                if (rise_chk) begin
                    check("R5 rises per period", rise_obs, rise_exp);
                    rise_chk = 0;
                    rise_obs = 0;
                end
                if (dclk_rise) rise_obs++;
            end
        end
    end

    task automatic drive_samples(input int c);
        case (c % 6)
            0: begin smp_a = 20'hFFFFF; smp_b = 20'h00000; end
            1: begin smp_a = 20'hAAAAA; smp_b = 20'h55555; end
            2: begin smp_a = 20'h80001; smp_b = 20'h7FFFE; end
            default: begin smp_a = 20'($urandom); smp_b = 20'($urandom); end
        endcase
    endtask

    initial begin
        rst = 1; smp_a = '0; smp_b = '0;
        cfg_wide = 0; cfg_two_lane = 0; cfg_ddr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int mode = 0; mode < 8; mode++) begin
            for (int c = 0; c < 230; c++) begin
                @(negedge clk);
                if (c == 17 + 3 * mode) begin
                    cfg_wide     = mode[2];
                    cfg_two_lane = mode[1];
                    cfg_ddr      = mode[0];
                end
                drive_samples(c + mode);
            end
            if (mode == 3) begin
                @(negedge clk); rst = 1;
                repeat (2) @(negedge clk);
                rst = 0;
            end
        end
        // rapid format toggling near boundaries
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (c % 7 == 0) begin
                cfg_wide     = 1'($urandom);
                cfg_two_lane = 1'($urandom);
                cfg_ddr      = 1'($urandom);
            end
            drive_samples(c);
        end
        repeat (100) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule